// File: doc/BRIEF.md
# Host Link Frame Receiver

This block sits behind the byte-level host interface and checks information frames as they arrive, one byte per cycle qualified by a valid strobe. It skips everything up to a `0x00 0xFF` start code. It then reads either a normal one-byte length with its checksum, or an extended header. An extended header is flagged by a `0xFF 0xFF` length/checksum pair and carries a 16-bit length with its own checksum. The block checks that the length is legal.

Once the header is accepted, the data field goes out on a byte stream. The identifier byte comes first and is marked. The command code, which is the byte after the identifier, is also presented on its own output. The parser then checks the data checksum and the closing `0x00` byte. Every frame that is started ends with a one-cycle done strobe that carries a two-bit error class. A clean frame also produces a one-cycle request for the transmit side to send an acknowledge frame.

Input may stall at any point by dropping the valid strobe. The parser holds its state until the next valid byte arrives.

Top module: `link_frame_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is low, including `dataValid`, `cmdValid`, `frameDone`, `frameOk`, `ackReq` and `errCode`.
- R2: Until a `0x00` byte is immediately followed by a `0xFF` byte, accepted bytes are discarded. No data, command or done strobe results from them.
- R3: In a normal header, if the low eight bits of length byte plus length checksum are not zero, the frame ends at the checksum byte with `errCode` = 1 and no data bytes are streamed. The pair `0xFF 0xFF` is exempt from this check.
- R4: A `0xFF 0xFF` length pair selects the extended header: length high byte, length low byte, then checksum. If the low eight bits of their sum are not zero, the frame ends at the checksum byte with `errCode` = 1.
- R5: A data-field length of zero, or above `MAX_LEN` (default 265, identifier included), ends the frame at the last header byte with `errCode` = 3 and no data bytes. A length of exactly `MAX_LEN` is accepted.
- R6: Each data-field byte appears on `dataByte` with `dataValid` for one cycle, exactly length bytes per frame, in arrival order. The first one (the identifier) also has `dataFirst` high.
- R7: The second data-field byte raises `cmdValid` for one cycle and is held on `cmdCode`. A frame with a length of one produces no `cmdValid`.
- R8: If the low eight bits of the sum of all data-field bytes plus the data checksum are not zero, the frame ends at the postamble byte with `errCode` = 2. This class takes priority over a bad postamble.
- R9: With a correct data checksum, a postamble other than `0x00` ends the frame with `errCode` = 3.
- R10: `ackReq` pulses for one cycle only together with `frameDone`, `frameOk` high and `errCode` = 0. This happens only after both checksums and the postamble are correct.
- R11: Data, command and done outputs are registered. Each becomes valid in the cycle following the clock edge that accepts the byte causing it.
- R12: After any frame ends, good or bad, the parser returns to hunting for a start code, so frames sent back to back are each decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte on `inByte` is accepted this cycle |
| inByte | input | 8 | Received byte |
| dataValid | output | 1 | Data-field byte on `dataByte` |
| dataByte | output | 8 | Data-field byte |
| dataFirst | output | 1 | Current data byte is the identifier |
| cmdValid | output | 1 | Command code present on `cmdCode` |
| cmdCode | output | 8 | Command code of the current frame |
| frameDone | output | 1 | One-cycle end-of-frame strobe |
| frameOk | output | 1 | Frame passed all checks (with `frameDone`) |
| errCode | output | 2 | 0 none, 1 length checksum, 2 data checksum, 3 malformed (with `frameDone`) |
| ackReq | output | 1 | One-cycle acknowledge request |

## Verification
Every result of this block is due exactly one clock after the edge that accepts the byte that causes it. That applies to a data byte, the command code, the early error on a bad header, and the done strobe at the postamble. The bench drives each byte at a falling edge. A monitor samples all outputs at the next falling edge, halfway through the cycle in which a registered result is valid. The monitor collects the results into counters and a capture buffer that each scenario compares with values derived from the frame it built. One scenario also reads `frameDone` just after the rising edge that took the postamble, and some frames are sent with idle gaps between bytes, so a result that is early, late or held for two cycles shows up as a wrong count.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  localparam logic [7:0] SYNC_LO  = 8'h00;
  localparam logic [7:0] SYNC_HI  = 8'hFF;
  localparam logic [7:0] EXT_FLAG = 8'hFF;
  localparam logic [7:0] POST_VAL = 8'h00;
  localparam int         EXT_LEN_W = 16;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_LCS  = 2'd1,
    ERR_DCS  = 2'd2,
    ERR_FORM = 2'd3
  } rxErr_e;

  typedef enum logic [3:0] {
    ST_HUNT0, ST_HUNTFF, ST_LEN, ST_LCS,
    ST_XHI, ST_XLO, ST_XLCS,
    ST_DATA, ST_DCS, ST_POST
  } rxState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capLen;
    logic capHi;
    logic capLo;
    logic startNorm;
    logic startExt;
    logic takeData;
    logic capDcs;
  } dpStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic lcsOk;
    logic extMark;
    logic xlcsOk;
    logic normBad;
    logic extBad;
    logic lastData;
    logic dcsGood;
  } dpFlag_t;

endpackage

// File: rtl/frame_rx_dp.sv
module frame_rx_dp
  import frame_rx_pkg::*;
#(
  parameter int MAX_LEN = 265
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [7:0] inByte,
  input  dpStrobe_t strobe,
  output dpFlag_t   flag,
  output logic      dataValid,
  output logic [7:0] dataByte,
  output logic      dataFirst,
  output logic      cmdValid,
  output logic [7:0] cmdCode
);

  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [7:0]           lenByte;
  logic [7:0]           hiByte;
  logic [7:0]           loByte;
  logic [7:0]           sumAcc;
  logic [CNT_W-1:0]     remain;
  logic [1:0]           pos;
  logic                 dcsGood;
  logic [EXT_LEN_W-1:0] extLen;

  assign extLen = {hiByte, loByte};

  always_comb begin
    flag.lcsOk    = 8'(lenByte + inByte) == 8'h00;
    flag.extMark  = (lenByte == EXT_FLAG) && (inByte == EXT_FLAG);
    flag.xlcsOk   = 8'(hiByte + loByte + inByte) == 8'h00;
    flag.normBad  = (lenByte == 8'h00) || (int'(lenByte) > MAX_LEN);
    flag.extBad   = (extLen == '0) || (int'(extLen) > MAX_LEN);
    flag.lastData = remain == CNT_W'(1);
    flag.dcsGood  = dcsGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenByte <= '0;
      hiByte  <= '0;
      loByte  <= '0;
      sumAcc  <= '0;
      remain  <= '0;
      pos     <= '0;
      dcsGood <= 1'b0;
    end else begin
      if (strobe.capLen) lenByte <= inByte;
      if (strobe.capHi)  hiByte  <= inByte;
      if (strobe.capLo)  loByte  <= inByte;
      if (strobe.startNorm) begin
        remain <= CNT_W'(lenByte);
        sumAcc <= '0;
        pos    <= '0;
      end else if (strobe.startExt) begin
        remain <= CNT_W'(extLen);
        sumAcc <= '0;
        pos    <= '0;
      end else if (strobe.takeData) begin
        sumAcc <= 8'(sumAcc + inByte);
        remain <= remain - CNT_W'(1);
        if (pos != 2'd2) pos <= pos + 2'd1;
      end
      if (strobe.capDcs) dcsGood <= 8'(sumAcc + inByte) == 8'h00;
    end
  end

  // registered data-field outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      dataByte  <= '0;
      dataFirst <= 1'b0;
      cmdValid  <= 1'b0;
      cmdCode   <= '0;
    end else begin
      dataValid <= strobe.takeData;
      dataFirst <= strobe.takeData && (pos == 2'd0);
      cmdValid  <= strobe.takeData && (pos == 2'd1);
      if (strobe.takeData) dataByte <= inByte;
      if (strobe.takeData && (pos == 2'd1)) cmdCode <= inByte;
    end
  end

endmodule

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  dpFlag_t    flag,
  output dpStrobe_t  strobe,
  output logic       frameDone,
  output logic       frameOk,
  output logic [1:0] errCode,
  output logic       ackReq
);

  rxState_e state, nextState;
  logic     finish;
  rxErr_e   finErr;

  always_comb begin
    strobe    = '0;
    nextState = state;
    finish    = 1'b0;
    finErr    = ERR_NONE;
    if (inValid) begin
      case (state)
        ST_HUNT0:  if (inByte == SYNC_LO) nextState = ST_HUNTFF;
        ST_HUNTFF: begin
          if (inByte == SYNC_HI)      nextState = ST_LEN;
          else if (inByte != SYNC_LO) nextState = ST_HUNT0;
        end
        ST_LEN: begin
          strobe.capLen = 1'b1;
          nextState     = ST_LCS;
        end
        ST_LCS: begin
          if (flag.extMark) nextState = ST_XHI;
          else if (!flag.lcsOk) begin
            finish = 1'b1;
            finErr = ERR_LCS;
          end else if (flag.normBad) begin
            finish = 1'b1;
            finErr = ERR_FORM;
          end else begin
            strobe.startNorm = 1'b1;
            nextState        = ST_DATA;
          end
        end
        ST_XHI: begin
          strobe.capHi = 1'b1;
          nextState    = ST_XLO;
        end
        ST_XLO: begin
          strobe.capLo = 1'b1;
          nextState    = ST_XLCS;
        end
        ST_XLCS: begin
          if (!flag.xlcsOk) begin
            finish = 1'b1;
            finErr = ERR_LCS;
          end else if (flag.extBad) begin
            finish = 1'b1;
            finErr = ERR_FORM;
          end else begin
            strobe.startExt = 1'b1;
            nextState       = ST_DATA;
          end
        end
        ST_DATA: begin
          strobe.takeData = 1'b1;
          if (flag.lastData) nextState = ST_DCS;
        end
        ST_DCS: begin
          strobe.capDcs = 1'b1;
          nextState     = ST_POST;
        end
        ST_POST: begin
          finish = 1'b1;
          if (!flag.dcsGood)          finErr = ERR_DCS;
          else if (inByte != POST_VAL) finErr = ERR_FORM;
        end
        default: nextState = ST_HUNT0;
      endcase
      if (finish) nextState = ST_HUNT0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT0;
      frameDone <= 1'b0;
      frameOk   <= 1'b0;
      errCode   <= ERR_NONE;
      ackReq    <= 1'b0;
    end else begin
      state     <= nextState;
      frameDone <= finish;
      frameOk   <= finish && (finErr == ERR_NONE);
      errCode   <= finish ? finErr : ERR_NONE;
      ackReq    <= finish && (finErr == ERR_NONE);
    end
  end

endmodule

// File: rtl/link_frame_rx.sv
module link_frame_rx
  import frame_rx_pkg::*;
#(
  parameter int MAX_LEN = 265
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inByte,
  output logic       dataValid,
  output logic [7:0] dataByte,
  output logic       dataFirst,
  output logic       cmdValid,
  output logic [7:0] cmdCode,
  output logic       frameDone,
  output logic       frameOk,
  output logic [1:0] errCode,
  output logic       ackReq
);

  dpStrobe_t strobe;
  dpFlag_t   flag;

  frame_rx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inByte    (inByte),
    .flag      (flag),
    .strobe    (strobe),
    .frameDone (frameDone),
    .frameOk   (frameOk),
    .errCode   (errCode),
    .ackReq    (ackReq)
  );

  frame_rx_dp #(.MAX_LEN(MAX_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inByte    (inByte),
    .strobe    (strobe),
    .flag      (flag),
    .dataValid (dataValid),
    .dataByte  (dataByte),
    .dataFirst (dataFirst),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode)
  );

endmodule

// File: rtl/link_frame_rx_chk.sv
module link_frame_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dataValid,
  input logic       dataFirst,
  input logic       cmdValid,
  input logic       frameDone,
  input logic       frameOk,
  input logic [1:0] errCode,
  input logic       ackReq
);

  // R10
  ack_only_when_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> (frameDone && frameOk && errCode == 2'd0));

  // R10
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> !ackReq);

  // R3
  err_only_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 2'd0) |-> (frameDone && !frameOk));

  // R6
  first_is_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataFirst |-> dataValid);

  // R7
  cmd_is_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (dataValid && !dataFirst));

  // R12
  done_apart_from_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!dataValid && $past(frameDone) == 1'b0));

endmodule

bind link_frame_rx link_frame_rx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dataValid (dataValid),
  .dataFirst (dataFirst),
  .cmdValid  (cmdValid),
  .frameDone (frameDone),
  .frameOk   (frameOk),
  .errCode   (errCode),
  .ackReq    (ackReq)
);

// File: tb/sim_link_frame_rx.sv
`timescale 1ns/1ps
module sim_link_frame_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       dataValid, dataFirst, cmdValid, frameDone, frameOk, ackReq;
  logic [7:0] dataByte, cmdCode;
  logic [1:0] errCode;

  always #5 clk = ~clk;

  link_frame_rx u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .dataValid(dataValid), .dataByte(dataByte), .dataFirst(dataFirst),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .frameDone(frameDone),
    .frameOk(frameOk), .errCode(errCode), .ackReq(ackReq)
  );

  int checks = 0;
  int fails  = 0;
  bit gapMode = 1'b0;

  // monitor state
  int         dataCnt, firstCnt, cmdCnt, doneCnt, ackCnt, okCnt, mismatch;
  logic [7:0] firstByte, cmdSeen;
  int         lastErr;
  logic [7:0] payload [0:299];
  logic [7:0] rxBuf   [0:299];

  always @(negedge clk) begin
    if (rstN) begin
      if (dataValid) begin
        if (dataCnt < 300) rxBuf[dataCnt] = dataByte;
        dataCnt++;
      end
      if (dataFirst) begin firstCnt++; firstByte = dataByte; end
      if (cmdValid)  begin cmdCnt++;   cmdSeen   = cmdCode;  end
      if (frameDone) begin doneCnt++;  lastErr   = int'(errCode); end
      if (frameOk)   okCnt++;
      if (ackReq)    ackCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(posedge clk); #1;
    dataCnt = 0; firstCnt = 0; cmdCnt = 0; doneCnt = 0;
    ackCnt = 0; okCnt = 0; lastErr = -1;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    if (gapMode) begin
      inValid = 1'b0;
      @(negedge clk);
    end
    inValid = 1'b1;
    inByte  = b;
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  // lenVal counts the identifier plus packet bytes
  task automatic sendFrame(input int lenVal, input bit ext, input bit badLcs,
                           input bit badDcs, input logic [7:0] post, input int seed);
    logic [7:0] sum;
    logic [7:0] hi, lo;
    sum = 8'h00;
    for (int i = 0; i < 300; i++) payload[i] = 8'(i * 7 + seed);
    sendByte(8'h00);
    sendByte(8'h00);
    sendByte(8'hFF);
    if (ext) begin
      hi = 8'(lenVal >> 8);
      lo = 8'(lenVal);
      sendByte(8'hFF);
      sendByte(8'hFF);
      sendByte(hi);
      sendByte(lo);
      sendByte(8'(8'h00 - hi - lo + (badLcs ? 8'h01 : 8'h00)));
    end else begin
      sendByte(8'(lenVal));
      sendByte(8'(8'h00 - 8'(lenVal) + (badLcs ? 8'h01 : 8'h00)));
    end
    if (badLcs || lenVal == 0 || lenVal > 265) return;
    for (int i = 0; i < lenVal; i++) begin
      sendByte(payload[i]);
      sum = 8'(sum + payload[i]);
    end
    sendByte(8'(8'h00 - sum + (badDcs ? 8'h01 : 8'h00)));
    sendByte(post);
  endtask

  task automatic checkData(input int n, input string req);
    mismatch = 0;
    for (int i = 0; i < n && i < 300; i++)
      if (rxBuf[i] !== payload[i]) mismatch++;
    check(mismatch == 0, req, mismatch, 0);
  endtask

  task automatic testReset();
    check({dataValid, dataFirst, cmdValid, frameDone, frameOk, ackReq, errCode} == 8'd0,
          "R1 outputs after reset",
          int'({dataValid, dataFirst, cmdValid, frameDone, frameOk, ackReq, errCode}), 0);
  endtask

  task automatic testJunkThenGood();
    clearMon();
    sendByte(8'h12); sendByte(8'h00); sendByte(8'h34); sendByte(8'hFF);
    sendByte(8'hFF); sendByte(8'h55);
    settle();
    check(doneCnt == 0 && dataCnt == 0, "R2 junk discarded", doneCnt + dataCnt, 0);
    clearMon();
    sendFrame(5, 1'b0, 1'b0, 1'b0, 8'h00, 3);
    #1;
    check(frameDone === 1'b1, "R11 done one cycle after postamble", int'(frameDone), 1);
    settle();
    check(doneCnt == 1 && okCnt == 1 && lastErr == 0, "R10 good normal frame", lastErr, 0);
    check(ackCnt == 1, "R10 ack pulse count", ackCnt, 1);
    check(dataCnt == 5, "R6 data byte count", dataCnt, 5);
    check(firstCnt == 1 && firstByte == payload[0], "R6 identifier marked",
          int'(firstByte), int'(payload[0]));
    check(cmdCnt == 1 && cmdSeen == payload[1], "R7 command code", int'(cmdSeen), int'(payload[1]));
    checkData(5, "R6 data order");
  endtask

  task automatic testBadLcs();
    clearMon();
    sendFrame(4, 1'b0, 1'b1, 1'b0, 8'h00, 9);
    settle();
    check(doneCnt == 1 && lastErr == 1, "R3 normal length checksum", lastErr, 1);
    check(dataCnt == 0 && ackCnt == 0, "R3 no data on bad header", dataCnt + ackCnt, 0);
  endtask

  task automatic testExtMax();
    clearMon();
    gapMode = 1'b1;
    sendFrame(265, 1'b1, 1'b0, 1'b0, 8'h00, 21);
    gapMode = 1'b0;
    settle();
    check(doneCnt == 1 && lastErr == 0 && ackCnt == 1, "R4 extended frame at limit", lastErr, 0);
    check(dataCnt == 265, "R5 length 265 accepted", dataCnt, 265);
    checkData(265, "R6 extended data order");
  endtask

  task automatic testExtOver();
    clearMon();
    sendFrame(266, 1'b1, 1'b0, 1'b0, 8'h00, 2);
    settle();
    check(doneCnt == 1 && lastErr == 3, "R5 extended oversize", lastErr, 3);
    check(dataCnt == 0, "R5 no data on oversize", dataCnt, 0);
  endtask

  task automatic testExtBadLcs();
    clearMon();
    sendFrame(20, 1'b1, 1'b1, 1'b0, 8'h00, 5);
    settle();
    check(doneCnt == 1 && lastErr == 1 && dataCnt == 0, "R4 extended length checksum", lastErr, 1);
  endtask

  task automatic testZeroLen();
    clearMon();
    sendFrame(0, 1'b0, 1'b0, 1'b0, 8'h00, 1);
    settle();
    check(doneCnt == 1 && lastErr == 3 && dataCnt == 0, "R5 normal zero length", lastErr, 3);
    clearMon();
    sendFrame(0, 1'b1, 1'b0, 1'b0, 8'h00, 1);
    settle();
    check(doneCnt == 1 && lastErr == 3 && dataCnt == 0, "R5 extended zero length", lastErr, 3);
  endtask

  task automatic testBadDcs();
    clearMon();
    sendFrame(6, 1'b0, 1'b0, 1'b1, 8'h07, 40);
    settle();
    check(doneCnt == 1 && lastErr == 2, "R8 data checksum over postamble", lastErr, 2);
    check(dataCnt == 6 && ackCnt == 0, "R8 data streamed, no ack", ackCnt, 0);
  endtask

  task automatic testBadPost();
    clearMon();
    sendFrame(3, 1'b0, 1'b0, 1'b0, 8'h5A, 11);
    settle();
    check(doneCnt == 1 && lastErr == 3 && ackCnt == 0, "R9 bad postamble", lastErr, 3);
  endtask

  task automatic testOneByte();
    clearMon();
    sendFrame(1, 1'b0, 1'b0, 1'b0, 8'h00, 77);
    settle();
    check(cmdCnt == 0, "R7 no command for length one", cmdCnt, 0);
    check(dataCnt == 1 && firstCnt == 1 && lastErr == 0, "R6 identifier only frame", dataCnt, 1);
  endtask

  task automatic testBackToBack();
    clearMon();
    sendFrame(3, 1'b1, 1'b0, 1'b0, 8'h00, 13);
    sendFrame(2, 1'b0, 1'b1, 1'b0, 8'h00, 14);
    sendFrame(4, 1'b0, 1'b0, 1'b0, 8'h00, 15);
    settle();
    check(doneCnt == 3 && ackCnt == 2, "R12 back-to-back frames", doneCnt, 3);
    check(dataCnt == 7 && lastErr == 0, "R12 data after recovery", dataCnt, 7);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({dataValid, cmdValid, frameDone, ackReq} == 4'd0, "R1 outputs during reset",
          int'({dataValid, cmdValid, frameDone, ackReq}), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testJunkThenGood();
    testBadLcs();
    testExtMax();
    testExtOver();
    testExtBadLcs();
    testZeroLen();
    testBadDcs();
    testBadPost();
    testOneByte();
    testBackToBack();
    finishRun();
  end

endmodule